// File: doc/BRIEF.md
# Physical Read Dispatcher with Typed Access Faults

This block takes one physical read request at a time and sends it to one of three places. The first is the register window of a core-local interruptor, covering the software-interrupt flag, the timer compare value and the timer value. The second is a two-word host-communication mailbox. The third is an external main-memory port. Each request carries an access kind (instruction fetch, data load, or a read made on behalf of a store or atomic), a physical address and a byte count of 1, 2, 4 or 8.

A request that hits a register window is answered from register values that are inputs to the block. A request that hits main memory goes out on the memory port, and the reply comes straight back. No target accepts a request in three cases: the address decodes nowhere, the offset inside a window is not a register, or the width is illegal. In each of these cases the block answers with an access fault whose type follows the access kind of the request.

Register windows are tested before main memory, so a memory range that overlaps a window never sees accesses inside that window. An access counts as inside a window only if every byte it touches lies in the window.

Top module: `rdd_read_dispatch`

## Requirements
- R1: The interruptor window and the mailbox window take priority over main memory. An access inside either window never produces a memory request, even when the memory range covers that address.
- R2: When no target accepts a request, `rsp_fault_o` follows the access kind on `req_kind_i`: kind 00 (fetch) gives 01, kind 01 (data load) gives 10, and kinds 10 and 11 give 11 (store/atomic fault). The returned data is zero.
- R3: In the interruptor window, the timer compare value sits at offset 0x4000 and the timer value at offset 0xBFF8. An 8-byte read at either offset returns the full 64 bits, and a 4-byte read returns the low word. A 4-byte read at offset 0x4004 returns the high word of the timer compare value, and one at 0xBFFC returns the high word of the timer value. Returned words are zero-extended.
- R4: The software-interrupt register at offset 0x0 accepts only 4- or 8-byte reads, and it returns the flag in bit 0 with all other bits zero. Any other width at that offset raises the kind-dependent fault of R2.
- R5: A read at an unmapped offset inside the interruptor window, or a read at a mapped offset with a width the register does not allow, raises the kind-dependent fault of R2. No memory request is made.
- R6: The mailbox window covers 8 bytes starting at `TOHOST_ADDR`. A 4-byte read at `TOHOST_ADDR` returns bits 31:0 of `tohost_i`, and one at `TOHOST_ADDR`+4 returns bits 63:32, each zero-extended. Any other width inside the window raises the kind-dependent fault of R2.
- R7: An access whose bytes extend past the end of a window is treated as outside that window. It goes on to the next decode step, and if it reaches the end of the decode order it faults.
- R8: `req_ready_o` is high only when the block is idle. A register-window hit or a fault answers with `rsp_valid_o` in the cycle after the request is accepted. `rsp_valid_o`, the data and the fault then hold steady until `rsp_ready_i` is high.
- R9: A main-memory hit raises `mem_req_valid_o` in the cycle after acceptance, carrying the address, byte count and access kind. These hold steady until `mem_req_ready_i` is high.
- R10: In the memory phase, `rsp_valid_o` follows `mem_rsp_valid_i` in the same cycle and `mem_rsp_ready_o` follows `rsp_ready_i`. The returned data is `mem_rsp_data_i` with every byte above the requested byte count forced to zero, and the fault code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Dispatcher is idle and can accept a request |
| req_kind_i | input | 2 | Access kind: 00 fetch, 01 data load, 10/11 store or atomic |
| req_addr_i | input | AW | Physical byte address |
| req_bytes_i | input | 4 | Byte count: 1, 2, 4 or 8 |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_data_o | output | 64 | Zero-extended read data |
| rsp_fault_o | output | 2 | 00 none, 01 fetch fault, 10 load fault, 11 store/atomic fault |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_addr_o | output | AW | Memory request address |
| mem_req_bytes_o | output | 4 | Memory request byte count |
| mem_req_kind_o | output | 2 | Memory request access kind |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_ready_o | output | 1 | Memory response accepted |
| mem_rsp_data_i | input | 64 | Memory response data |
| sw_irq_i | input | 1 | Software-interrupt flag |
| tcmp_i | input | 64 | Timer compare value |
| tval_i | input | 64 | Timer value |
| tohost_i | input | 64 | Mailbox register |

## Verification
The bench places the interruptor window at 0x0200_0000, the mailbox at 0x0200_F000, and a 64 KiB memory range that starts at the same base as the interruptor window. Because of this overlap, one short address range exercises the window-over-memory priority, the straddling accesses that fall through to memory at the ends of both windows, and a read that runs off the end of memory and faults. The memory responder returns non-zero bytes above each requested width, so the width masking can be observed at the ports. Each fault path is driven with every access kind, and backpressure is applied on both the memory port and the response port.

// File: rtl/rdd_pkg.sv
package rdd_pkg;

  localparam int unsigned DW = 64;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_FETCH = 2'b01,
    FLT_LOAD  = 2'b10,
    FLT_STAMO = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RSP,
    ST_MREQ,
    ST_MWAIT
  } state_e;

  function automatic fault_e fault_for(input logic [1:0] kind);
    case (kind)
      2'b00:   return FLT_FETCH;
      2'b01:   return FLT_LOAD;
      default: return FLT_STAMO;
    endcase
  endfunction

  function automatic logic [DW-1:0] byte_mask(input logic [3:0] nbytes);
    case (nbytes)
      4'd1:    return 64'h0000_0000_0000_00FF;
      4'd2:    return 64'h0000_0000_0000_FFFF;
      4'd4:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/rdd_window.sv
module rdd_window #(
  parameter int unsigned   AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] LEN  = 'h1000
) (
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    bytes_i,
  output logic          hit_o
);
  localparam logic [AW:0] WIN_END = {1'b0, BASE} + {1'b0, LEN};

  logic [AW:0] acc_end;
  assign acc_end = {1'b0, addr_i} + (AW+1)'(bytes_i);
  // every touched byte must lie inside
  assign hit_o   = (addr_i >= BASE) && (acc_end <= WIN_END);
endmodule

// File: rtl/rdd_clint_read.sv
module rdd_clint_read #(
  parameter int unsigned   AW   = 32,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    bytes_i,
  input  logic          sw_irq_i,
  input  logic [63:0]   tcmp_i,
  input  logic [63:0]   tval_i,
  output logic          ok_o,
  output logic [63:0]   data_o
);
  localparam logic [AW-1:0] OFF_SWI     = AW'(32'h0000_0000);
  localparam logic [AW-1:0] OFF_TCMP    = AW'(32'h0000_4000);
  localparam logic [AW-1:0] OFF_TCMP_HI = AW'(32'h0000_4004);
  localparam logic [AW-1:0] OFF_TVAL    = AW'(32'h0000_BFF8);
  localparam logic [AW-1:0] OFF_TVAL_HI = AW'(32'h0000_BFFC);

  logic [AW-1:0] off;
  logic          w4, w8;

  assign off = addr_i - BASE;
  assign w4  = (bytes_i == 4'd4);
  assign w8  = (bytes_i == 4'd8);

  always_comb begin
    ok_o   = 1'b0;
    data_o = '0;
    if (off == OFF_SWI) begin
      ok_o   = w4 || w8;
      data_o = {63'd0, sw_irq_i};
    end else if (off == OFF_TCMP) begin
      ok_o   = w4 || w8;
      data_o = w8 ? tcmp_i : {32'd0, tcmp_i[31:0]};
    end else if (off == OFF_TCMP_HI) begin
      ok_o   = w4;
      data_o = {32'd0, tcmp_i[63:32]};
    end else if (off == OFF_TVAL) begin
      ok_o   = w4 || w8;
      data_o = w8 ? tval_i : {32'd0, tval_i[31:0]};
    end else if (off == OFF_TVAL_HI) begin
      ok_o   = w4;
      data_o = {32'd0, tval_i[63:32]};
    end
    if (!ok_o) data_o = '0;
  end
endmodule

// File: rtl/rdd_host_read.sv
module rdd_host_read #(
  parameter int unsigned   AW          = 32,
  parameter logic [AW-1:0] TOHOST_ADDR = '0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    bytes_i,
  input  logic [63:0]   tohost_i,
  output logic          ok_o,
  output logic [63:0]   data_o
);
  localparam logic [AW-1:0] HI_ADDR = TOHOST_ADDR + AW'(4);

  logic lo_hit, hi_hit;

  assign lo_hit = (bytes_i == 4'd4) && (addr_i == TOHOST_ADDR);
  assign hi_hit = (bytes_i == 4'd4) && (addr_i == HI_ADDR);
  assign ok_o   = lo_hit || hi_hit;

  always_comb begin
    data_o = '0;
    if (lo_hit)      data_o = {32'd0, tohost_i[31:0]};
    else if (hi_hit) data_o = {32'd0, tohost_i[63:32]};
  end
endmodule

// File: rtl/rdd_read_dispatch.sv
module rdd_read_dispatch
  import rdd_pkg::*;
#(
  parameter int unsigned   AW          = 32,
  parameter logic [AW-1:0] CLINT_BASE  = 32'h0200_0000,
  parameter logic [AW-1:0] CLINT_LEN   = 32'h0000_C000,
  parameter logic [AW-1:0] TOHOST_ADDR = 32'h4000_1000,
  parameter logic [AW-1:0] MEM_BASE    = 32'h8000_0000,
  parameter logic [AW-1:0] MEM_LEN     = 32'h1000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_kind_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [3:0]    req_bytes_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [63:0]   rsp_data_o,
  output logic [1:0]    rsp_fault_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [3:0]    mem_req_bytes_o,
  output logic [1:0]    mem_req_kind_o,
  input  logic          mem_rsp_valid_i,
  output logic          mem_rsp_ready_o,
  input  logic [63:0]   mem_rsp_data_i,
  input  logic          sw_irq_i,
  input  logic [63:0]   tcmp_i,
  input  logic [63:0]   tval_i,
  input  logic [63:0]   tohost_i
);
  localparam logic [AW-1:0] HOST_LEN = AW'(8);

  state_e        st_q;
  logic [63:0]   data_q;
  fault_e        fault_q;
  logic [AW-1:0] addr_q;
  logic [3:0]    bytes_q;
  logic [1:0]    kind_q;

  logic          clint_hit, host_hit, mem_hit;
  logic          clint_ok, host_ok;
  logic [63:0]   clint_data, host_data;
  logic          req_fire;

  rdd_window #(.AW(AW), .BASE(CLINT_BASE), .LEN(CLINT_LEN)) u_win_clint (
    .addr_i(req_addr_i), .bytes_i(req_bytes_i), .hit_o(clint_hit));
  rdd_window #(.AW(AW), .BASE(TOHOST_ADDR), .LEN(HOST_LEN)) u_win_host (
    .addr_i(req_addr_i), .bytes_i(req_bytes_i), .hit_o(host_hit));
  rdd_window #(.AW(AW), .BASE(MEM_BASE), .LEN(MEM_LEN)) u_win_mem (
    .addr_i(req_addr_i), .bytes_i(req_bytes_i), .hit_o(mem_hit));

  rdd_clint_read #(.AW(AW), .BASE(CLINT_BASE)) u_clint (
    .addr_i(req_addr_i), .bytes_i(req_bytes_i), .sw_irq_i(sw_irq_i),
    .tcmp_i(tcmp_i), .tval_i(tval_i), .ok_o(clint_ok), .data_o(clint_data));

  rdd_host_read #(.AW(AW), .TOHOST_ADDR(TOHOST_ADDR)) u_host (
    .addr_i(req_addr_i), .bytes_i(req_bytes_i), .tohost_i(tohost_i),
    .ok_o(host_ok), .data_o(host_data));

  assign req_ready_o = (st_q == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      data_q  <= '0;
      fault_q <= FLT_NONE;
      addr_q  <= '0;
      bytes_q <= '0;
      kind_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_fire) begin
          addr_q  <= req_addr_i;
          bytes_q <= req_bytes_i;
          kind_q  <= req_kind_i;
          // register windows first, then memory, then fault
          if (clint_hit) begin
            st_q    <= ST_RSP;
            data_q  <= clint_ok ? clint_data : '0;
            fault_q <= clint_ok ? FLT_NONE : fault_for(req_kind_i);
          end else if (host_hit) begin
            st_q    <= ST_RSP;
            data_q  <= host_ok ? host_data : '0;
            fault_q <= host_ok ? FLT_NONE : fault_for(req_kind_i);
          end else if (mem_hit) begin
            st_q    <= ST_MREQ;
          end else begin
            st_q    <= ST_RSP;
            data_q  <= '0;
            fault_q <= fault_for(req_kind_i);
          end
        end
        ST_RSP:   if (rsp_ready_i) st_q <= ST_IDLE;
        ST_MREQ:  if (mem_req_ready_i) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid_i && rsp_ready_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (st_q == ST_MREQ);
  assign mem_req_addr_o  = addr_q;
  assign mem_req_bytes_o = bytes_q;
  assign mem_req_kind_o  = kind_q;
  assign mem_rsp_ready_o = (st_q == ST_MWAIT) && rsp_ready_i;

  assign rsp_valid_o = (st_q == ST_RSP) || ((st_q == ST_MWAIT) && mem_rsp_valid_i);
  assign rsp_data_o  = (st_q == ST_MWAIT) ? (mem_rsp_data_i & byte_mask(bytes_q)) : data_q;
  assign rsp_fault_o = (st_q == ST_MWAIT) ? FLT_NONE : fault_q;

  // R1: a window hit never turns into a memory request
  p_window_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && (clint_hit || host_hit)) |=> (!mem_req_valid_o && rsp_valid_o));

  // R2: faulted responses carry no data
  p_fault_no_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> (rsp_data_o == '0));

  // R4: software-interrupt register only at widths 4 and 8
  p_swi_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && clint_hit && clint_ok && req_addr_i == CLINT_BASE)
      |-> (req_bytes_i == 4'd4 || req_bytes_i == 4'd8));

  // R6: mailbox accepts only 4-byte reads
  p_host_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && host_hit && host_ok) |-> (req_bytes_i == 4'd4));

  // R8: busy right after acceptance
  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire |=> !req_ready_o);

  // R8: held local response stays stable
  p_rsp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RSP && !rsp_ready_i)
      |=> (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_fault_o)));

  // R9: memory request held under backpressure
  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i)
      |=> (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_bytes_o)));

  // R10: memory-phase response handshake tracks the port
  p_mem_fwd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_ready_o) |-> (rsp_ready_i && rsp_fault_o == FLT_NONE));
endmodule

// File: tb/rdd_read_dispatch_test.sv
module rdd_read_dispatch_test;
  localparam logic [31:0] CB = 32'h0200_0000;
  localparam logic [31:0] CL = 32'h0000_C000;
  localparam logic [31:0] TH = 32'h0200_F000;
  localparam logic [31:0] MB = 32'h0200_0000;
  localparam logic [31:0] ML = 32'h0001_0000;

  localparam logic [63:0] TCMP   = 64'h1122_3344_5566_7788;
  localparam logic [63:0] TVAL   = 64'h0F0E_0D0C_0B0A_0908;
  localparam logic [63:0] TOHOST = 64'hDEAD_BEEF_CAFE_F00D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_bytes = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_data;
  logic [1:0]  rsp_fault;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic [31:0] mreq_addr;
  logic [3:0]  mreq_bytes;
  logic [1:0]  mreq_kind;
  logic        mrsp_valid = 1'b0;
  logic        mrsp_ready;
  logic [63:0] mrsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rdd_read_dispatch #(
    .AW(32), .CLINT_BASE(CB), .CLINT_LEN(CL), .TOHOST_ADDR(TH),
    .MEM_BASE(MB), .MEM_LEN(ML)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_bytes_i(req_bytes),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data), .rsp_fault_o(rsp_fault),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_addr_o(mreq_addr), .mem_req_bytes_o(mreq_bytes), .mem_req_kind_o(mreq_kind),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_ready_o(mrsp_ready), .mem_rsp_data_i(mrsp_data),
    .sw_irq_i(1'b1), .tcmp_i(TCMP), .tval_i(TVAL), .tohost_i(TOHOST)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit in_win(input longint a, input longint s, input longint b, input longint l);
    return (a >= b) && (a + s <= b + l);
  endfunction

  function automatic logic [1:0] kind_fault(input logic [1:0] k);
    if (k == 2'b00) return 2'b01;
    if (k == 2'b01) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_A5A5};
  endfunction

  function automatic logic [63:0] width_mask(input int s);
    if (s == 1) return 64'hFF;
    if (s == 2) return 64'hFFFF;
    if (s == 4) return 64'hFFFF_FFFF;
    return '1;
  endfunction

  // behavioural reference for a single request
  task automatic model(input logic [1:0] k, input logic [31:0] a, input int s,
                       output bit to_mem, output logic [63:0] d, output logic [1:0] f);
    longint off;
    bit ok;
    to_mem = 1'b0; d = '0; f = 2'b00; ok = 1'b0;
    if (in_win(a, s, CB, CL)) begin
      off = longint'(a) - longint'(CB);
      if (off == 0 && (s == 4 || s == 8)) begin ok = 1; d = 64'd1; end
      else if (off == 'h4000 && s == 8) begin ok = 1; d = TCMP; end
      else if (off == 'h4000 && s == 4) begin ok = 1; d = {32'd0, TCMP[31:0]}; end
      else if (off == 'h4004 && s == 4) begin ok = 1; d = {32'd0, TCMP[63:32]}; end
      else if (off == 'hBFF8 && s == 8) begin ok = 1; d = TVAL; end
      else if (off == 'hBFF8 && s == 4) begin ok = 1; d = {32'd0, TVAL[31:0]}; end
      else if (off == 'hBFFC && s == 4) begin ok = 1; d = {32'd0, TVAL[63:32]}; end
      if (!ok) begin d = '0; f = kind_fault(k); end
    end else if (in_win(a, s, TH, 8)) begin
      if (s == 4 && a == TH) d = {32'd0, TOHOST[31:0]};
      else if (s == 4 && a == TH + 4) d = {32'd0, TOHOST[63:32]};
      else f = kind_fault(k);
    end else if (in_win(a, s, MB, ML)) begin
      to_mem = 1'b1;
      d = mem_word(a) & width_mask(s);
    end else begin
      f = kind_fault(k);
    end
  endtask

  task automatic run(input string req, input logic [1:0] k, input logic [31:0] a,
                     input int s, input int lat, input int hold);
    bit to_mem;
    logic [63:0] ed;
    logic [1:0]  ef;
    model(k, a, s, to_mem, ed, ef);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_bytes = 4'(s);
    chk(req, "req_ready idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "req_ready busy", 64'(req_ready), 64'd0);
    if (!to_mem) begin
      chk(req, "no mem request", 64'(mreq_valid), 64'd0);
      for (int i = 0; i < hold; i++) begin
        chk(req, "held rsp_valid", 64'(rsp_valid), 64'd1);
        chk(req, "held data", rsp_data, ed);
        chk(req, "held fault", 64'(rsp_fault), 64'(ef));
        @(negedge clk);
        chk(req, "no mem request", 64'(mreq_valid), 64'd0);
      end
      chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(req, "rsp_data", rsp_data, ed);
      chk(req, "rsp_fault", 64'(rsp_fault), 64'(ef));
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req, "rsp done", 64'(rsp_valid), 64'd0);
      chk(req, "idle again", 64'(req_ready), 64'd1);
    end else begin
      chk(req, "no early rsp", 64'(rsp_valid), 64'd0);
      for (int i = 0; i <= lat; i++) begin
        chk(req, "mem_req_valid", 64'(mreq_valid), 64'd1);
        chk(req, "mem_req_addr", 64'(mreq_addr), 64'(a));
        chk(req, "mem_req_bytes", 64'(mreq_bytes), 64'(s));
        chk(req, "mem_req_kind", 64'(mreq_kind), 64'(k));
        if (i == lat) mreq_ready = 1'b1;
        @(negedge clk);
      end
      mreq_ready = 1'b0;
      chk(req, "mem req taken", 64'(mreq_valid), 64'd0);
      chk(req, "wait for mem", 64'(rsp_valid), 64'd0);
      mrsp_valid = 1'b1;
      mrsp_data  = mem_word(a);
      rsp_ready  = (hold == 0);
      #1;
      chk(req, "fwd rsp_valid", 64'(rsp_valid), 64'd1);
      chk(req, "fwd data masked", rsp_data, ed);
      chk(req, "fwd fault none", 64'(rsp_fault), 64'd0);
      chk(req, "fwd mem_rsp_ready", 64'(mrsp_ready), 64'(hold == 0));
      if (hold != 0) begin
        @(negedge clk);
        rsp_ready = 1'b1;
        #1;
        chk(req, "fwd data after hold", rsp_data, ed);
        chk(req, "fwd mem_rsp_ready", 64'(mrsp_ready), 64'd1);
      end
      @(negedge clk);
      mrsp_valid = 1'b0;
      rsp_ready  = 1'b0;
      #1;
      chk(req, "rsp done", 64'(rsp_valid), 64'd0);
      chk(req, "idle again", 64'(req_ready), 64'd1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R8", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R9", "reset mem_req_valid", 64'(mreq_valid), 64'd0);
    rst_n = 1'b1;

    // R2: unmapped address, every access kind
    for (int k = 0; k < 4; k++) run("R2", 2'(k), 32'h1000_0000, 4, 0, 0);
    // R3: timer registers
    run("R3", 2'b01, CB + 32'h4000, 8, 0, 0);
    run("R3", 2'b01, CB + 32'h4000, 4, 0, 0);
    run("R3", 2'b00, CB + 32'h4004, 4, 0, 0);
    run("R3", 2'b01, CB + 32'hBFF8, 8, 0, 2);
    run("R3", 2'b01, CB + 32'hBFF8, 4, 0, 0);
    run("R3", 2'b10, CB + 32'hBFFC, 4, 0, 0);
    // R4: software-interrupt register widths
    run("R4", 2'b01, CB, 4, 0, 0);
    run("R4", 2'b01, CB, 8, 0, 0);
    run("R4", 2'b00, CB, 2, 0, 0);
    run("R4", 2'b10, CB, 1, 0, 0);
    // R5 / R1: unmapped offset and bad width inside the window, memory overlaps
    run("R5", 2'b00, CB + 32'h10, 4, 0, 0);
    run("R5", 2'b10, CB + 32'h10, 4, 0, 1);
    run("R5", 2'b01, CB + 32'h4004, 8, 0, 0);
    run("R1", 2'b11, CB + 32'h8000, 2, 0, 0);
    // R6: mailbox
    run("R6", 2'b01, TH, 4, 0, 0);
    run("R6", 2'b01, TH + 4, 4, 0, 0);
    run("R6", 2'b00, TH, 8, 0, 0);
    run("R6", 2'b10, TH + 2, 2, 0, 0);
    // R9 / R10: memory hits with backpressure and width masking
    run("R9", 2'b01, MB + 32'hC010, 2, 3, 0);
    run("R10", 2'b00, MB + 32'hC100, 1, 0, 2);
    run("R10", 2'b10, MB + 32'hD004, 4, 1, 0);
    run("R10", 2'b01, MB + 32'hE008, 8, 0, 1);
    // R7: straddling the end of a window
    run("R7", 2'b01, CB + 32'hBFFC, 8, 0, 0);
    run("R7", 2'b01, TH + 4, 8, 0, 0);
    run("R7", 2'b00, MB + ML - 4, 8, 0, 0);
    run("R7", 2'b10, MB + ML - 2, 4, 0, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule